// File: doc/BRIEF.md
# PLL Ratio Search Engine

This block turns a requested output rate and a reference input rate, both unsigned 32-bit values in hertz, into a feedback multiplier N and a reference divider M for a fractional-ratio PLL. A request at or below the reference selects bypass. Any other request is first clamped into the legal VCO window of 80 MHz to 230 MHz. The ratio is then reduced by the greatest common divisor of the clamped rate and the reference. That divisor comes from an iterative binary GCD unit, and the two quotients come from serial restoring dividers.

If the reduced pair is still too wide for the 12-bit N field or the 9-bit M field, both values are shifted right together, one bit per cycle, until both fit. A value that shifts down to zero is raised to one. A reference of zero is flagged as an error and answered with bypass. The achieved rate is reference×N/M. When N equals M, or when both are zero, the PLL passes the reference through unchanged, and the block reports that case as bypass.

The block accepts a request with a single-cycle start while idle. It pulses done for one cycle when the new N, M, bypass and error values appear at its outputs.

Top module: `pll_ratio_search`

## Requirements
- R1: When rate_i <= ref_i and ref_i != 0, the result is n_o = 0, m_o = 0, bypass_o = 1, err_o = 0. A computed result with n_o == m_o also sets bypass_o = 1.
- R2: When ref_i == 0, the result is err_o = 1, bypass_o = 1, n_o = 0, m_o = 0.
- R3: When rate_i > ref_i, the request is first clamped to the range [80_000_000, 230_000_000].
- R4: With g = gcd(clamped rate, ref_i), the unshifted results are N = clamped/g and M = ref_i/g.
- R5: While N > 4095 or M > 511, N and M are both shifted right by one bit in the same step.
- R6: After shifting, an N or M that reached 0 is output as 1, so a non-bypass result never carries a zero field.
- R7: Each accepted start produces exactly one done_o pulse, one cycle wide. busy_o is high from the cycle after a start that needs computation until done_o.
- R8: start_i while busy_o is high is ignored. The result in progress completes unchanged, and no extra done_o follows.
- R9: n_o, m_o, bypass_o and err_o hold their values except in the cycle where done_o is high. They reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, accepted only while idle |
| rate_i | input | 32 | Requested output rate in Hz |
| ref_i | input | 32 | Reference input rate in Hz |
| busy_o | output | 1 | A computation is in progress |
| done_o | output | 1 | One-cycle pulse: results updated |
| n_o | output | 12 | Feedback multiplier N |
| m_o | output | 9 | Reference divider M |
| bypass_o | output | 1 | Result means the PLL is bypassed |
| err_o | output | 1 | Reference rate was zero |

## Verification
The bench targets requests just above the reference and exactly at each clamp edge. A design that skipped or misordered the clamp would return ratios for rates outside the VCO window. A coprime pair at full 32-bit width forces many shift steps. Shifting N and M independently, or stopping at the wrong width, would give a distorted ratio there. A tiny reference drives M to zero after shifting, which exposes a missing fix-up as a zero divider. The bench also covers a clamp that lands exactly on the reference, a zero reference, and a start issued mid-run. Mishandling any of these shows up as a missed bypass flag, a lost error, a corrupted result or a second done pulse.

// File: rtl/pll_ratio_pkg.sv
package pll_ratio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GCD,
    ST_DIV,
    ST_FIT
  } ratio_state_e;
endpackage

// File: rtl/pll_gcd_bin.sv
module pll_gcd_bin #(
  parameter int W = 32,
  localparam int KW = $clog2(W) + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         done_o,
  output logic [W-1:0] gcd_o
);
  logic [W-1:0]  a_q, b_q;
  logic [KW-1:0] k_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; k_q <= '0; run_q <= 1'b0;
      done_o <= 1'b0; gcd_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        a_q <= a_i; b_q <= b_i; k_q <= '0; run_q <= 1'b1;
      end else if (run_q) begin
        if (a_q == '0) begin
          gcd_o <= b_q << k_q; done_o <= 1'b1; run_q <= 1'b0;
        end else if (b_q == '0) begin
          gcd_o <= a_q << k_q; done_o <= 1'b1; run_q <= 1'b0;
        end else if (!a_q[0] && !b_q[0]) begin
          a_q <= a_q >> 1; b_q <= b_q >> 1; k_q <= k_q + 1'b1;
        end else if (!a_q[0]) begin
          a_q <= a_q >> 1;
        end else if (!b_q[0]) begin
          b_q <= b_q >> 1;
        end else if (a_q >= b_q) begin
          a_q <= (a_q - b_q) >> 1;  // both odd: difference is even
        end else begin
          b_q <= (b_q - a_q) >> 1;
        end
      end
    end
  end

  // R4
  gcd_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> gcd_o != '0);
endmodule

// File: rtl/pll_div_seq.sv
module pll_div_seq #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  logic [W-1:0]  q_q, r_q, d_q, n_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    trial;
  logic          fits;

  always_comb begin
    trial = {r_q, q_q[W-1]};
    fits  = trial >= {1'b0, d_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0; r_q <= '0; d_q <= '0; n_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        q_q <= num_i; r_q <= '0; d_q <= den_i; n_q <= num_i;
        cnt_q <= CW'(W); run_q <= 1'b1;
      end else if (run_q) begin
        r_q   <= fits ? W'(trial - {1'b0, d_q}) : trial[W-1:0];
        q_q   <= {q_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0; done_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = q_q;

  // R4
  div_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((2*W)'(q_q) * (2*W)'(d_q) + (2*W)'(r_q)) == (2*W)'(n_q));
  // R4
  div_rem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> r_q < d_q);
endmodule

// File: rtl/pll_ratio_search.sv
module pll_ratio_search
  import pll_ratio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_W    = 12,
  parameter int M_W    = 9,
  parameter logic [DATA_W-1:0] VCO_MIN = 80_000_000,
  parameter logic [DATA_W-1:0] VCO_MAX = 230_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] rate_i,
  input  logic [DATA_W-1:0] ref_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [N_W-1:0]    n_o,
  output logic [M_W-1:0]    m_o,
  output logic              bypass_o,
  output logic              err_o
);
  localparam logic [DATA_W-1:0] N_LIM = DATA_W'((64'd1 << N_W) - 1);
  localparam logic [DATA_W-1:0] M_LIM = DATA_W'((64'd1 << M_W) - 1);

  ratio_state_e      state_q;
  logic [DATA_W-1:0] rate_q, ref_q, n_w, m_w, rate_c, gcd_v;
  logic              gcd_go_q, div_go_q, gcd_done;
  logic [1:0]        div_done;
  logic [DATA_W-1:0] div_quo [2];
  logic              too_wide;
  logic [N_W-1:0]    n_fix;
  logic [M_W-1:0]    m_fix;

  always_comb begin
    if (rate_i < VCO_MIN)      rate_c = VCO_MIN;
    else if (rate_i > VCO_MAX) rate_c = VCO_MAX;
    else                       rate_c = rate_i;
    too_wide = (n_w > N_LIM) || (m_w > M_LIM);
    n_fix = (n_w == '0) ? N_W'(1) : n_w[N_W-1:0];
    m_fix = (m_w == '0) ? M_W'(1) : m_w[M_W-1:0];
  end

  pll_gcd_bin #(.W(DATA_W)) u_gcd (
    .clk_i, .rst_ni, .go_i(gcd_go_q), .a_i(rate_q), .b_i(ref_q),
    .done_o(gcd_done), .gcd_o(gcd_v)
  );

  // slot 0: M = ref/g, slot 1: N = rate/g
  for (genvar i = 0; i < 2; i++) begin : g_div
    pll_div_seq #(.W(DATA_W)) u_div (
      .clk_i, .rst_ni, .go_i(div_go_q),
      .num_i((i == 0) ? ref_q : rate_q), .den_i(gcd_v),
      .done_o(div_done[i]), .quo_o(div_quo[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rate_q <= '0; ref_q <= '0; n_w <= '0; m_w <= '0;
      gcd_go_q <= 1'b0; div_go_q <= 1'b0;
      done_o <= 1'b0; n_o <= '0; m_o <= '0; bypass_o <= 1'b0; err_o <= 1'b0;
    end else begin
      gcd_go_q <= 1'b0;
      div_go_q <= 1'b0;
      done_o   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (ref_i == '0) begin
            n_o <= '0; m_o <= '0; bypass_o <= 1'b1; err_o <= 1'b1; done_o <= 1'b1;
          end else if (rate_i <= ref_i) begin
            n_o <= '0; m_o <= '0; bypass_o <= 1'b1; err_o <= 1'b0; done_o <= 1'b1;
          end else begin
            rate_q <= rate_c; ref_q <= ref_i; gcd_go_q <= 1'b1; state_q <= ST_GCD;
          end
        end
        ST_GCD: if (gcd_done) begin
          div_go_q <= 1'b1; state_q <= ST_DIV;
        end
        ST_DIV: if (&div_done) begin
          n_w <= div_quo[1]; m_w <= div_quo[0]; state_q <= ST_FIT;
        end
        ST_FIT: if (too_wide) begin
          n_w <= n_w >> 1; m_w <= m_w >> 1;
        end else begin
          n_o <= n_fix; m_o <= m_fix; err_o <= 1'b0;
          bypass_o <= (DATA_W'(n_fix) == DATA_W'(m_fix));
          done_o <= 1'b1; state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R7
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R8
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(rate_q) && $stable(ref_q)));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(n_o) && $stable(m_o) && $stable(bypass_o) && $stable(err_o)));
  // R2
  err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (bypass_o && n_o == '0 && m_o == '0));
  // R5
  fit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIT && !too_wide) |=> done_o);
  // R6
  nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (n_o == '0 || m_o == '0)) |-> (bypass_o && n_o == '0 && m_o == '0));
endmodule

// File: tb/pll_ratio_search_test.sv
`timescale 1ns/1ps
module pll_ratio_search_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] rate = '0, refr = '0;
  logic        busy, done, byp, err;
  logic [11:0] n;
  logic [8:0]  m;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pll_ratio_search uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rate_i(rate), .ref_i(refr),
    .busy_o(busy), .done_o(done), .n_o(n), .m_o(m), .bypass_o(byp), .err_o(err)
  );

  localparam int NV = 13;
  localparam logic [31:0] V_RATE [NV] = '{
    32'd100_000_000, 32'd0, 32'd50_000_000, 32'd150_000_000, 32'd300_000_000,
    32'd100_000_001, 32'd230_000_000, 32'd300_000_000, 32'd5, 32'd80_000_000,
    32'd230_000_000, 32'd20_000_001, 32'd4_294_967_295};
  localparam logic [31:0] V_REF [NV] = '{
    32'd100_000_000, 32'd10, 32'd25_000_000, 32'd25_000_000, 32'd27_000_000,
    32'd27_000_000, 32'd1, 32'd230_000_000, 32'd0, 32'd10_000_000,
    32'd10_000_000, 32'd20_000_000, 32'd4_294_967_291};

  function automatic string tag_of(int i);
    case (i)
      0, 1, 7:   return "R1";
      8:         return "R2";
      2, 4, 9, 10, 11: return "R3";
      3:         return "R4";
      6:         return "R6";
      default:   return "R5";
    endcase
  endfunction

  // expected values straight from the requirements
  task automatic model(input logic [31:0] r, input logic [31:0] f,
                       output logic [11:0] en, output logic [8:0] em,
                       output logic eb, output logic ee);
    longint unsigned rc, a, b, t, nn, mm;
    ee = 1'b0;
    if (f == 0) begin
      en = 0; em = 0; eb = 1'b1; ee = 1'b1;
    end else if (r <= f) begin
      en = 0; em = 0; eb = 1'b1;
    end else begin
      rc = (r < 80_000_000) ? 80_000_000 : (r > 230_000_000) ? 230_000_000 : longint'(r);
      a = rc; b = longint'(f);
      while (b != 0) begin t = a % b; a = b; b = t; end
      nn = rc / a; mm = longint'(f) / a;
      while (nn > 4095 || mm > 511) begin nn = nn >> 1; mm = mm >> 1; end
      if (nn == 0) nn = 1;
      if (mm == 0) mm = 1;
      en = nn[11:0]; em = mm[8:0]; eb = (nn == mm);
    end
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [31:0] r, input logic [31:0] f);
    @(negedge clk);
    rate = r; refr = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int cnt = 0;
    while (!done && cnt < 2000) begin @(negedge clk); cnt++; end
    ok = done;
    if (!ok) chk("R7", "done timeout", 0, 1);
  endtask

  task automatic check_result(input string req, input logic [31:0] r, input logic [31:0] f);
    logic [11:0] en; logic [8:0] em; logic eb, ee;
    model(r, f, en, em, eb, ee);
    chk(req, "n", n, en);
    chk(req, "m", m, em);
    chk(req, "bypass", byp, eb);
    chk(req, "err", err, ee);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    logic [11:0] hn; logic [8:0] hm;
    int extra;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9", "reset n", n, 0);
    chk("R9", "reset m", m, 0);
    chk("R9", "reset bypass", byp, 0);
    chk("R9", "reset err", err, 0);
    chk("R7", "reset done", done, 0);
    chk("R7", "reset busy", busy, 0);

    for (int i = 0; i < NV; i++) begin
      pulse_start(V_RATE[i], V_REF[i]);
      wait_done(ok);
      if (ok) begin
        check_result(tag_of(i), V_RATE[i], V_REF[i]);
        @(negedge clk);
        chk("R7", "done width", done, 0);
      end
    end

    // R9: hold after done while idle, and while a new run is in progress
    hn = n; hm = m;
    repeat (5) @(negedge clk);
    chk("R9", "idle hold n", n, hn);
    chk("R9", "idle hold m", m, hm);
    pulse_start(32'd150_000_000, 32'd25_000_000);
    chk("R7", "busy during run", busy, 1);
    repeat (3) @(negedge clk);
    chk("R9", "run hold n", n, hn);
    chk("R9", "run hold m", m, hm);
    wait_done(ok);
    if (ok) check_result("R4", 32'd150_000_000, 32'd25_000_000);

    // R8: second start while busy is ignored
    pulse_start(32'd100_000_001, 32'd27_000_000);
    @(negedge clk);
    rate = 32'd150_000_000; refr = 32'd25_000_000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    if (ok) check_result("R8", 32'd100_000_001, 32'd27_000_000);
    extra = 0;
    repeat (300) begin @(negedge clk); if (done) extra++; end
    chk("R8", "extra done pulses", extra, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule